// File: doc/BRIEF.md
# CPU-Fed PCM Sample Channel

This block plays one channel of 8-bit unsigned PCM audio. The host processor writes sample bytes into a 256-entry queue. A 12-bit period timer sets how long each byte stays on the output. A 4-bit volume factor then scales the byte about the midpoint value 0x80, which stands for silence. The timer advances only on a one-cycle tick input, which is normally one pulse per processor cycle.

The channel starts by itself when a byte arrives while it is idle. It stops by itself when a sample ends and the queue holds nothing more. A new period is picked up only when the next sample is loaded. A new volume changes the output at once.

The host uses four write strobes that share one data bus: flush, push, period low byte, and period high nibble with volume. A status byte reports whether the queue is full or empty. Mixing several channels and converting to analogue are left to the surrounding logic.

Top module: `pcm_fifo_channel`

## Requirements
- R1: After reset the channel is idle (`active_o`=0), `sample_o` is 0x80 and `status_o` is 0x40.
- R2: Each accepted push stores one byte in a 256-entry queue. `status_o` bit 7 is 1 exactly when 256 bytes are stored. Bit 6 is 1 exactly when none are stored. Bits 5..0 always read 0.
- R3: A push while the queue is full is discarded: that byte never reaches the output.
- R4: When the channel is idle and the queue is not empty, the head byte is popped and playback starts on the next clock edge. A push to an idle, empty channel therefore shows its byte two edges after the write edge.
- R5: Each sample stays on the output for P+1 tick pulses. P = {high-register bits [3:0], low-register byte}. Clock edges without a tick do not advance playback.
- R6: A period write during a sample does not change that sample's length. The new period applies from the next sample loaded.
- R7: The volume V is taken from high-register bits [7:4] and applies on the edge after the write. While active, `sample_o` = 0x80 + trunc((s - 128) * V / 15), where s is the playing byte and trunc rounds toward zero.
- R8: When a sample ends and the queue is empty, the channel goes idle and `sample_o` returns to 0x80.
- R9: A flush write makes the channel idle and empties the queue on that edge. A push in the same cycle is discarded.
- R10: A push and a pop on the same edge both take effect, so back-to-back pushes with P=0 play on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse that advances the period timer |
| flush_we_i | input | 1 | Write strobe: stop the channel and empty the queue |
| push_we_i | input | 1 | Write strobe: push `wdata_i` into the queue |
| per_lo_we_i | input | 1 | Write strobe: low 8 bits of the period |
| per_hi_we_i | input | 1 | Write strobe: period bits [11:8] from `wdata_i[3:0]`, volume from `wdata_i[7:4]` |
| wdata_i | input | 8 | Write data shared by all strobes |
| status_o | output | 8 | Bit 7 queue full, bit 6 queue empty, other bits zero |
| sample_o | output | 8 | Volume-scaled unsigned sample, 0x80 when idle |
| active_o | output | 1 | Channel is playing |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host push and a timer-driven pop. The bench provokes it by pushing three bytes on consecutive cycles with a zero period and the tick held high. It then requires the three bytes to appear in order on consecutive cycles, followed by idle. The second pair is a flush together with a push. The bench asserts both strobes on the same edge and requires the channel to stay idle with the queue empty. A period write that lands in the middle of a sample is also checked: the current sample must keep its length and the following sample must take the new one.

// File: rtl/pcm_chan_pkg.sv
package pcm_chan_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   localparam byte_t MID_LEVEL = byte_t'(1 << (BYTE_W - 1));
   localparam int unsigned ST_FULL_BIT  = 7;
   localparam int unsigned ST_EMPTY_BIT = 6;
endpackage

// File: rtl/pcm_byte_fifo.sv
module pcm_byte_fifo #(
   parameter int unsigned W  = 8,
   parameter int unsigned AW = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         full_o,
   output logic         empty_o
);
   localparam int unsigned DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("pcm_byte_fifo: AW out of range");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   level;
   logic          do_push, do_pop;

   assign full_o  = (level == (AW+1)'(DEPTH));
   assign empty_o = (level == '0);
   assign do_push = push_i && !full_o && !clr_i;
   assign do_pop  = pop_i && !empty_o && !clr_i;
   assign head_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
   parameter int unsigned PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [PW-1:0] load_val_i,
   input  logic          tick_i,
   output logic          at_zero_o
);
   logic [PW-1:0] cnt;

   assign at_zero_o = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load_i)             cnt <= load_val_i;
      else if (tick_i && !at_zero_o) cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/pcm_vol_scaler.sv
module pcm_vol_scaler #(
   parameter int unsigned W  = 8,
   parameter int unsigned VW = 4
) (
   input  logic [W-1:0]  sample_i,
   input  logic [VW-1:0] vol_i,
   output logic [W-1:0]  scaled_o
);
   localparam int unsigned VOL_MAX = (1 << VW) - 1;
   localparam int unsigned MW      = W + VW + 2;
   localparam logic [W-1:0] MID    = W'(1 << (W - 1));

   generate
      if (VOL_MAX == 1) begin : g_gate
         assign scaled_o = vol_i[0] ? sample_i : MID;
      end else begin : g_div
         logic signed [MW-1:0] offset, prod, quo, biased;
         always_comb begin
            offset = $signed(MW'(sample_i)) - $signed(MW'(MID));
            prod   = offset * $signed(MW'(vol_i));
            quo    = prod / $signed(MW'(VOL_MAX));
            biased = quo + $signed(MW'(MID));
         end
         assign scaled_o = biased[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/pcm_fifo_channel.sv
module pcm_fifo_channel #(
   parameter int unsigned FIFO_AW = 8,
   parameter int unsigned PER_W   = 12,
   parameter int unsigned VOL_W   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       flush_we_i,
   input  logic       push_we_i,
   input  logic       per_lo_we_i,
   input  logic       per_hi_we_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] status_o,
   output logic [7:0] sample_o,
   output logic       active_o
);
   import pcm_chan_pkg::*;

   localparam int unsigned HI_W = PER_W - BYTE_W;

   generate
      if (PER_W <= BYTE_W || HI_W + VOL_W > BYTE_W || VOL_W < 1) begin : g_bad_cfg
         $error("pcm_fifo_channel: period/volume widths do not fit the data bus");
      end
   endgenerate

   byte_t             per_lo_q;
   logic [HI_W-1:0]   per_hi_q;
   logic [VOL_W-1:0]  vol_q;
   byte_t             cur_q;
   logic              active_q;

   byte_t             fifo_head, scaled;
   logic              fifo_full, fifo_empty, tmr_zero;
   logic              start_play, sample_end, pop_now;

   assign start_play = !active_q && !fifo_empty && !flush_we_i;
   assign sample_end = active_q && tick_i && tmr_zero && !flush_we_i;
   assign pop_now    = start_play || (sample_end && !fifo_empty);

   pcm_byte_fifo #(.W(BYTE_W), .AW(FIFO_AW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (flush_we_i),
      .push_i  (push_we_i),
      .din_i   (wdata_i),
      .pop_i   (pop_now),
      .head_o  (fifo_head),
      .full_o  (fifo_full),
      .empty_o (fifo_empty)
   );

   pcm_period_timer #(.PW(PER_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (pop_now),
      .load_val_i ({per_hi_q, per_lo_q}),
      .tick_i     (tick_i && active_q),
      .at_zero_o  (tmr_zero)
   );

   pcm_vol_scaler #(.W(BYTE_W), .VW(VOL_W)) u_scale (
      .sample_i (cur_q),
      .vol_i    (vol_q),
      .scaled_o (scaled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_lo_q <= '0;
         per_hi_q <= '0;
         vol_q    <= '0;
      end else begin
         if (per_lo_we_i) per_lo_q <= wdata_i;
         if (per_hi_we_i) begin
            per_hi_q <= wdata_i[HI_W-1:0];
            vol_q    <= wdata_i[BYTE_W-1 -: VOL_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= MID_LEVEL;
      end else begin
         if (pop_now) cur_q <= fifo_head;
         if (flush_we_i)                    active_q <= 1'b0;
         else if (start_play)               active_q <= 1'b1;
         else if (sample_end && fifo_empty) active_q <= 1'b0;
      end
   end

   always_comb begin
      status_o               = '0;
      status_o[ST_FULL_BIT]  = fifo_full;
      status_o[ST_EMPTY_BIT] = fifo_empty;
   end

   assign sample_o = active_q ? scaled : MID_LEVEL;
   assign active_o = active_q;
endmodule

// File: rtl/pcm_fifo_channel_chk.sv
module pcm_fifo_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       flush_we_i,
   input logic       push_we_i,
   input logic       per_hi_we_i,
   input logic [7:0] status_o,
   input logic [7:0] sample_o,
   input logic       active_o
);
   p_idle_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> sample_o == 8'h80);

   p_flag_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_o[7] && status_o[6]) && status_o[5:0] == 6'd0);

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_we_i |=> !active_o && status_o == 8'h40);

   p_autostart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && push_we_i && !flush_we_i) ##1 !flush_we_i |=> active_o);

   p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active_o && !tick_i && !flush_we_i && !per_hi_we_i |=> active_o && $stable(sample_o));

   p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] && !tick_i && !flush_we_i |=> status_o[7]);
endmodule

bind pcm_fifo_channel pcm_fifo_channel_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .flush_we_i  (flush_we_i),
   .push_we_i   (push_we_i),
   .per_hi_we_i (per_hi_we_i),
   .status_o    (status_o),
   .sample_o    (sample_o),
   .active_o    (active_o)
);

// File: tb/pcm_fifo_channel_tb.sv
module pcm_fifo_channel_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       flush_we_i = 1'b0, push_we_i = 1'b0, per_lo_we_i = 1'b0, per_hi_we_i = 1'b0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] status_o, sample_o;
   logic       active_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_fifo_channel u_dut (
      .clk, .rst_n, .tick_i, .flush_we_i, .push_we_i, .per_lo_we_i, .per_hi_we_i,
      .wdata_i, .status_o, .sample_o, .active_o
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int expect_out(input int s, input int v);
      return 128 + ((s - 128) * v) / 15;
   endfunction

   // kind: 0 flush, 1 push, 2 period low, 3 period high + volume
   task automatic wr(input int kind, input logic [7:0] d);
      wdata_i     = d;
      flush_we_i  = (kind == 0);
      push_we_i   = (kind == 1);
      per_lo_we_i = (kind == 2);
      per_hi_we_i = (kind == 3);
      @(negedge clk);
      {flush_we_i, push_we_i, per_lo_we_i, per_hi_we_i} = 4'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int run;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(active_o == 1'b0, "R1", active_o, 0);
      chk(sample_o == 8'h80, "R1", sample_o, 8'h80);
      chk(status_o == 8'h40, "R1", status_o, 8'h40);

      // R7 / R4: sweep every byte against every volume, timer frozen
      tick_i = 1'b0;
      wr(2, 8'h00);
      for (int s = 0; s < 256; s++) begin
         wr(0, 8'h00);
         wr(3, 8'hF0);
         wr(1, 8'(s));
         @(negedge clk);
         chk(active_o == 1'b1, "R4", active_o, 1);
         for (int v = 0; v < 16; v++) begin
            wr(3, {4'(v), 4'h0});
            chk(sample_o == 8'(expect_out(s, v)), "R7", sample_o, expect_out(s, v));
         end
      end
      wr(0, 8'h00);
      chk(active_o == 1'b0 && status_o == 8'h40, "R9", {status_o, 7'b0, active_o}, 16'h4000);

      // R5 tick gating: frozen without ticks, one tick at P=0 advances
      wr(3, 8'hF0);
      wr(1, 8'h21);
      wr(1, 8'h42);
      repeat (10) @(negedge clk);
      chk(sample_o == 8'h21, "R5", sample_o, 8'h21);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk(sample_o == 8'h42, "R5", sample_o, 8'h42);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk(active_o == 1'b0, "R8", active_o, 0);

      // R5 / R6: period 2 then rewritten to 5 in mid-sample
      wr(2, 8'h02);
      tick_i = 1'b1;
      wr(1, 8'h30);
      wr(1, 8'h50);
      run = (sample_o == 8'h30) ? 1 : 0;
      per_lo_we_i = 1'b1; wdata_i = 8'h05;
      @(negedge clk);
      per_lo_we_i = 1'b0;
      if (sample_o == 8'h30) run++;
      @(negedge clk);
      for (int g = 0; g < 20 && sample_o == 8'h30; g++) begin run++; @(negedge clk); end
      chk(run == 3, "R5", run, 3);
      run = 0;
      for (int g = 0; g < 20 && sample_o == 8'h50; g++) begin run++; @(negedge clk); end
      chk(run == 6, "R6", run, 6);
      chk(active_o == 1'b0 && sample_o == 8'h80, "R8", sample_o, 8'h80);
      chk(status_o == 8'h40, "R8", status_o, 8'h40);

      // R10: push/pop coincide at P=0 with tick every cycle
      wr(2, 8'h00);
      wr(1, 8'hA1);
      wr(1, 8'hB2);
      chk(sample_o == 8'hA1, "R10", sample_o, 8'hA1);
      wr(1, 8'hC3);
      chk(sample_o == 8'hB2, "R10", sample_o, 8'hB2);
      @(negedge clk);
      chk(sample_o == 8'hC3, "R10", sample_o, 8'hC3);
      @(negedge clk);
      chk(active_o == 1'b0, "R10", active_o, 0);

      // R9: flush and push in the same cycle
      flush_we_i = 1'b1; push_we_i = 1'b1; wdata_i = 8'h77;
      @(negedge clk);
      {flush_we_i, push_we_i} = 2'b0;
      @(negedge clk);
      @(negedge clk);
      chk(active_o == 1'b0 && status_o == 8'h40, "R9", {status_o, 7'b0, active_o}, 16'h4000);

      // R2 / R3: fill the queue, overflow, then drain in order
      tick_i = 1'b0;
      for (int i = 0; i < 256; i++) wr(1, 8'(i));
      chk(status_o == 8'h00, "R2", status_o, 8'h00);
      wr(1, 8'h00);
      chk(status_o == 8'h80, "R2", status_o, 8'h80);
      wr(1, 8'h11);
      chk(status_o == 8'h80, "R3", status_o, 8'h80);
      tick_i = 1'b1;
      for (int j = 0; j <= 256; j++) begin
         chk(sample_o == 8'(j), "R2", sample_o, j & 255);
         @(negedge clk);
      end
      chk(active_o == 1'b0 && sample_o == 8'h80, "R3", sample_o, 8'h80);
      tick_i = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule